// File: doc/BRIEF.md
# Sampling Converter Bus Port

This block is the digital face of a 12-bit sampling converter toward a processor bus that may be 8 or 16 bits wide. A host read, made by pulling chip select and the read strobe low together, does two things at once: it returns the result held from the last conversion and it starts the next conversion. A byte-select input lets an 8-bit host fetch the four upper result bits on the low data lines in a second read. That second read never starts a conversion.

The converter core is outside the block. The block sends it a one-cycle start pulse and waits for a one-cycle done pulse that comes with the 12-bit result. The done pulse acts as a valid with no ready: the port always accepts it in the same cycle, so the core never sees back-pressure. An active-low BUSY flag is low from the start of a conversion until the result has been latched. The three-state data bus appears as a data vector and one enable. The data vector reads zero while the enable is low, which models a released bus. All host strobes are asynchronous and each passes through a two-flop synchroniser.

Top module: `adc_bus_port`

## Requirements
- R1: After reset, busy_n is 1, conv_start is 0, data_oe is 0, data_out is 0 and the held result is 0.
- R2: data_oe is 1 only while the synchronised cs_n and rd_n are both 0. While data_oe is 0, data_out is all zeros.
- R3: With data_oe high and hbyte low, data_out[11:0] equals the held 12-bit result, right justified (bit 0 on data_out[0]).
- R4: With data_oe high and hbyte high, data_out[3:0] and data_out[11:8] both carry result bits 11..8, and data_out[7:4] is 0.
- R5: A fall of the synchronised combined select (cs_n and rd_n both low) while hbyte is low and the port is idle gives a conv_start pulse exactly one cycle long. busy_n goes low in that same cycle.
- R6: During the read that starts a conversion, data_out shows the result of the previous conversion.
- R7: A conv_done pulse during a conversion loads conv_result into the held result and raises busy_n at the same clock edge. busy_n is never high before the new result is held.
- R8: A read with hbyte high produces no conv_start and leaves busy_n high.
- R9: A new read edge that arrives while busy_n is low produces no conv_start and does not end the conversion.
- R10: A conv_done pulse while idle (busy_n high) leaves the held result unchanged.
- R11: A conversion starts only on the edge of the select. Holding cs_n and rd_n low across the end of a conversion starts no further conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| hbyte | input | 1 | High-byte select for two-read access |
| conv_done | input | 1 | One-cycle end-of-conversion pulse from the core |
| conv_result | input | 12 | Result word, valid with conv_done |
| conv_start | output | 1 | One-cycle conversion start to the core |
| busy_n | output | 1 | Low while a conversion is in flight |
| data_out | output | 12 | Data bus value |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the port with its default 12-bit result, 8-bit byte and two synchroniser stages. It pairs the port with a converter stub whose conversion time is 20 cycles. That time is long enough for a second read edge to land inside a conversion, which reaches R9. It is also short enough that a read held low across a whole conversion sees the new result appear on the bus, which reaches R11 and R7. Injected idle done pulses and high-byte reads then show that the held result and the BUSY flag stay untouched when they should.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_CONV = 1'b1
  } port_state_t;
endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[gi] <= rst_val;
          else        stage_q[gi] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[gi] <= rst_val;
          else        stage_q[gi] <= stage_q[gi-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/adc_start_ctl.sv
module adc_start_ctl
  import adc_bus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s,
  input  logic hb_s,
  input  logic conv_done,
  output logic conv_start,
  output logic busy_n,
  output logic load_en
);
  port_state_t state_q, state_d;
  logic        sel_q;
  logic        start_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_s;

  assign start_evt = sel_s && !sel_q && !hb_s && (state_q == PS_IDLE);
  assign load_en   = conv_done && (state_q == PS_CONV);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_IDLE: if (start_evt) state_d = PS_CONV;
      PS_CONV: if (conv_done) state_d = PS_IDLE;
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q    <= PS_IDLE;
      conv_start <= 1'b0;
      busy_n     <= 1'b1;
    end else begin
      state_q    <= state_d;
      conv_start <= start_evt;
      busy_n     <= (state_d == PS_IDLE);
    end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start) else $error("start pulse too long"); // R5
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !busy_n) else $error("start without busy"); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && !conv_done) |=> !conv_start) else $error("start while busy"); // R9
  AST_NO_START_HBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    hb_s |=> !conv_start) else $error("start on high byte read"); // R8
endmodule

// File: rtl/adc_out_mux.sv
module adc_out_mux #(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [RES_W-1:0] new_result,
  input  logic             sel_s,
  input  logic             hb_s,
  output logic [RES_W-1:0] held,
  output logic [RES_W-1:0] data_out,
  output logic             data_oe
);
  localparam int NIB_W = RES_W - BYTE_W;

  logic [BYTE_W-1:0] low_lines;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       held <= '0;
    else if (load_en) held <= new_result;

  always_comb begin
    if (hb_s) low_lines = {{(BYTE_W-NIB_W){1'b0}}, held[RES_W-1:BYTE_W]};
    else      low_lines = held[BYTE_W-1:0];
  end

  assign data_oe  = sel_s;
  assign data_out = sel_s ? {held[RES_W-1:BYTE_W], low_lines} : '0;

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0)) else $error("bus driven while off"); // R2
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(held)) else $error("held result moved"); // R10
endmodule

// File: rtl/adc_bus_port.sv
module adc_bus_port #(
  parameter int RES_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             hbyte,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             conv_start,
  output logic             busy_n,
  output logic [RES_W-1:0] data_out,
  output logic             data_oe
);
  logic [2:0]       strobe_s;
  logic             sel_s, hb_s, load_en;
  logic [RES_W-1:0] held;

  adc_strobe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({hbyte, rd_n, cs_n}),
    .rst_val(3'b011),
    .sync_out(strobe_s)
  );

  assign sel_s = !strobe_s[0] && !strobe_s[1];
  assign hb_s  = strobe_s[2];

  adc_start_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .hb_s(hb_s),
    .conv_done(conv_done), .conv_start(conv_start),
    .busy_n(busy_n), .load_en(load_en)
  );

  adc_out_mux #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .new_result(conv_result),
    .sel_s(sel_s), .hb_s(hb_s), .held(held),
    .data_out(data_out), .data_oe(data_oe)
  );

  AST_LATCH_BEFORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (held == $past(conv_result))) else $error("busy rose early"); // R7
  AST_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_out[RES_W-1:BYTE_W] == held[RES_W-1:BYTE_W])) else $error("upper lines wrong"); // R3
endmodule

// File: tb/adc_bus_port_tb.sv
module adc_bus_port_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int CONV_CYCLES = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, hbyte = 1'b0;
  logic        stub_done = 1'b0, inj_done = 1'b0;
  logic [11:0] stub_val = '0;
  logic        conv_start, busy_n, data_oe;
  logic [11:0] data_out;
  int          cnt = 0, starts = 0, errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hbyte(hbyte),
    .conv_done(stub_done | inj_done), .conv_result(stub_val),
    .conv_start(conv_start), .busy_n(busy_n),
    .data_out(data_out), .data_oe(data_oe)
  );

  always @(posedge clk) begin
    stub_done <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) stub_done <= 1'b1;
    end else if (conv_start) cnt <= CONV_CYCLES;
    if (conv_start) starts <= starts + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd_on(input logic hb);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; hbyte = hb;
    wait_cyc(4);
  endtask

  task automatic rd_off();
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    check("R1 busy_n", busy_n, 1);
    check("R1 conv_start", conv_start, 0);
    check("R1 data_oe", data_oe, 0);
    check("R1 data_out", data_out, 0);
  endtask

  task automatic t_enable();
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; wait_cyc(4);
    check("R2 oe cs only", data_oe, 0);
    check("R2 data cs only", data_out, 0);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; wait_cyc(4);
    check("R2 oe rd only", data_oe, 0);
    check("R8 no start on partial", starts, 0);
    rd_off();
  endtask

  task automatic t_two_conversions();
    stub_val = 12'hA5C;
    rd_on(1'b0);
    check("R5 busy low", busy_n, 0);
    check("R5 one start", starts, 1);
    check("R6 previous result (reset)", data_out, 12'h000);
    check("R2 oe on", data_oe, 1);
    rd_off();
    wait_cyc(CONV_CYCLES + 4);
    check("R7 busy back high", busy_n, 1);
    stub_val = 12'h3C7;
    rd_on(1'b0);
    check("R6 previous result", data_out, 12'hA5C);
    check("R3 full word", data_out, 12'hA5C);
    rd_off();
    wait_cyc(CONV_CYCLES + 4);
    rd_on(1'b1);
    check("R4 high byte", data_out, 12'h303);
    check("R8 no start", starts, 2);
    check("R8 busy high", busy_n, 1);
    rd_off();
  endtask

  task automatic t_busy_ignore();
    stub_val = 12'h9E1;
    rd_on(1'b0);
    rd_off();
    rd_on(1'b0);
    check("R9 start ignored", starts, 3);
    check("R9 still busy", busy_n, 0);
    rd_off();
    wait_cyc(CONV_CYCLES);
    check("R7 busy high", busy_n, 1);
    rd_on(1'b1);
    check("R7 new result held", data_out, 12'h909);
    rd_off();
  endtask

  task automatic t_idle_done();
    stub_val = 12'h777;
    @(negedge clk); inj_done = 1'b1;
    @(negedge clk); inj_done = 1'b0;
    wait_cyc(2);
    check("R10 busy untouched", busy_n, 1);
    rd_on(1'b1);
    check("R10 held unchanged", data_out, 12'h909);
    rd_off();
  endtask

  task automatic t_hold_low();
    stub_val = 12'h456;
    rd_on(1'b0);
    check("R6 previous during hold", data_out, 12'h9E1);
    wait_cyc(CONV_CYCLES + 10);
    check("R11 single start", starts, 4);
    check("R11 busy high", busy_n, 1);
    check("R7 new data on bus", data_out, 12'h456);
    rd_off();
    check("R11 no later start", starts, 4);
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(3);
    t_enable();
    t_two_conversions();
    t_busy_ignore();
    t_idle_done();
    t_hold_low();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule